// File: doc/BRIEF.md
# Character RAM Host Load Port

This block lets a host processor fill a display character memory through two byte-wide write ports. The first port is a control register. It holds the display mode flags, the two high bits of the character address, and a select bit that decides how the second port behaves. The second port is shared between address and data. While the select bit is set, a write to it is captured as the low address byte. While the select bit is clear, a write to it stores the byte into the character memory.

A host loads one character with four writes:
1. Write the control port with the select bit set and the two high address bits.
2. Write the shared port with the low address byte.
3. Write the control port with the select bit cleared.
4. Write the shared port with the character byte.

Each host write is a level strobe. A write takes effect on the clock edge at which the strobe is first seen low again. When readout is switched on, the memory address is taken from an external scan position counter instead of the host latch, so the display scan can walk the memory. A registered read port returns the word at the current memory address.

Top module: `charram_load_port`

## Requirements
- R1: While reset is high, and on the first edge after reset, all control outputs (`readout_on`, `addr_mode`, `maxspan_dot`, `lines16`, `chars40`, `spec_clip_en`) are 0, `ram_we` is 0, and `ram_addr` is 0.
- R2: A write with `wr_sel`=0 loads the control register. The bit fields are:
  - bit 0: readout on
  - bit 1: address select
  - bit 2: address bit 9
  - bit 3: max-span dot position
  - bit 4: address bit 8
  - bit 5: 16-line mode
  - bit 6: 40-character mode
  - bit 7: clipped spectrum display enable

  Each flag appears on its own output pin.
- R3: A write with `wr_sel`=1 while address select is 1 latches the 10-bit address {control bit 2, control bit 4, byte}.
- R4: While address select is 1, a shared-port write never raises `ram_we` and leaves memory contents unchanged.
- R5: A shared-port write with address select 0 raises `ram_we` for exactly one cycle, with `ram_wdata` equal to the full byte (bits 5..0 character code, bit 6 skip-line, bit 7 blank). The byte is stored at `ram_addr`. `ram_wdata` changes only together with `ram_we`.
- R6: When readout is on, `ram_addr` equals `scan_pos` one cycle later. When readout is off, `ram_addr` equals the latched host address.
- R7: A write commits on the first clock edge at which `wr_valid` is sampled low after being high. It uses the byte and port select from the last cycle that `wr_valid` was high. While the strobe is held high, nothing changes.
- R8: `rd_data` is the memory word at `ram_addr`, one cycle after `ram_addr` is presented.
- R9: Rewriting address bits 8 and 9 in the control register after the low byte has been latched does not move the latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write strobe, level; the write commits at its trailing edge |
| wr_sel | input | 1 | 0 = control port, 1 = shared address/data port |
| wr_byte | input | 8 | Host write byte |
| scan_pos | input | 10 | Display scan position counter |
| readout_on | output | 1 | Control bit 0 |
| addr_mode | output | 1 | Control bit 1, address select |
| maxspan_dot | output | 1 | Control bit 3 |
| lines16 | output | 1 | Control bit 5 |
| chars40 | output | 1 | Control bit 6 |
| spec_clip_en | output | 1 | Control bit 7 |
| ram_addr | output | 10 | Registered memory address |
| ram_we | output | 1 | Memory write strobe, one cycle |
| ram_wdata | output | 8 | Memory write data |
| rd_data | output | 8 | Registered memory read data |

## Verification
Take the clock edge at which `wr_valid` is first sampled low as edge 0.
- Control outputs, the address latch, `ram_we` and `ram_wdata` update on edge 0.
- `ram_addr` follows the latch, or `scan_pos`, one edge later.
- The memory is written on that same following edge.
- `rd_data` reflects a new address one edge after `ram_addr` changes.

The bench drives inputs on the falling edge and samples results on a falling edge. It samples `ram_we` right after edge 0, the address two falling edges later, and read data three falling edges later. Every comparison therefore lands in the cycle where the result is due.

// File: rtl/charram_pkg.sv
package charram_pkg;

  localparam int unsigned BYTE_W = 8;

  // Control register layout, MSB first (bit 7 .. bit 0).
  typedef struct packed {
    logic spec_clip;   // bit 7
    logic chars40;     // bit 6
    logic lines16;     // bit 5
    logic a8;          // bit 4
    logic maxspan;     // bit 3
    logic a9;          // bit 2
    logic addr_sel;    // bit 1
    logic readout;     // bit 0
  } ctrl_t;

endpackage

// File: rtl/charram_host_regs.sv
module charram_host_regs
  import charram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_byte,
  output ctrl_t             ctrl_q,
  output logic [ADDR_W-1:0] addr_latch_q,
  output logic              we_q,
  output logic [BYTE_W-1:0] wdata_q
);

  logic              valid_q;
  logic              hold_sel;
  logic [BYTE_W-1:0] hold_byte;
  logic              commit;

  // Trailing edge of the host strobe.
  assign commit = valid_q & ~wr_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q      <= 1'b0;
      hold_sel     <= 1'b0;
      hold_byte    <= '0;
      ctrl_q       <= '0;
      addr_latch_q <= '0;
      we_q         <= 1'b0;
      wdata_q      <= '0;
    end else begin
      valid_q <= wr_valid;
      we_q    <= 1'b0;

      if (wr_valid) begin
        hold_sel  <= wr_sel;
        hold_byte <= wr_byte;
      end

      if (commit) begin
        if (!hold_sel) begin
          ctrl_q <= ctrl_t'(hold_byte);
        end else if (ctrl_q.addr_sel) begin
          addr_latch_q <= ADDR_W'({ctrl_q.a9, ctrl_q.a8, hold_byte});
        end else begin
          we_q    <= 1'b1;
          wdata_q <= hold_byte;
        end
      end
    end
  end

endmodule

// File: rtl/charram_addr_mux.sv
module charram_addr_mux #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_sel,
  input  logic [ADDR_W-1:0] scan_pos,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [ADDR_W-1:0] ram_addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr_q <= '0;
    end else begin
      ram_addr_q <= scan_sel ? scan_pos : host_addr;
    end
  end

endmodule

// File: rtl/charram_mem.sv
module charram_mem #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    rdata <= mem[addr];
  end

endmodule

// File: rtl/charram_load_port.sv
module charram_load_port
  import charram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [ADDR_W-1:0] scan_pos,
  output logic              readout_on,
  output logic              addr_mode,
  output logic              maxspan_dot,
  output logic              lines16,
  output logic              chars40,
  output logic              spec_clip_en,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic [BYTE_W-1:0] rd_data
);

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] host_addr;

  charram_host_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .wr_sel       (wr_sel),
    .wr_byte      (wr_byte),
    .ctrl_q       (ctrl),
    .addr_latch_q (host_addr),
    .we_q         (ram_we),
    .wdata_q      (ram_wdata)
  );

  charram_addr_mux #(.ADDR_W(ADDR_W)) mux_i (
    .clk        (clk),
    .rst        (rst),
    .scan_sel   (ctrl.readout),
    .scan_pos   (scan_pos),
    .host_addr  (host_addr),
    .ram_addr_q (ram_addr)
  );

  charram_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) mem_i (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (rd_data)
  );

  assign readout_on   = ctrl.readout;
  assign addr_mode    = ctrl.addr_sel;
  assign maxspan_dot  = ctrl.maxspan;
  assign lines16      = ctrl.lines16;
  assign chars40      = ctrl.chars40;
  assign spec_clip_en = ctrl.spec_clip;

endmodule

// File: rtl/charram_load_port_chk.sv
module charram_load_port_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_sel,
  input logic [ADDR_W-1:0] scan_pos,
  input logic              readout_on,
  input logic              addr_mode,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_we,
  input logic [7:0]        ram_wdata
);

  // R4: no memory write while address select is set.
  a_r4_no_we_in_addr_mode: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !addr_mode);

  // R5 / R7: write strobe follows a shared-port strobe trailing edge.
  a_r5_we_after_trailing_edge: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(wr_valid, 2) && !$past(wr_valid) && $past(wr_sel, 2)));

  // R5: write strobe is a single-cycle pulse.
  a_r5_we_single_cycle: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);

  // R5: write data only moves together with a write.
  a_r5_wdata_isolated: assert property (@(posedge clk) disable iff (rst)
    !$stable(ram_wdata) |-> ram_we);

  // R6: readout on steers the scan position onto the memory address.
  a_r6_scan_mux: assert property (@(posedge clk) disable iff (rst)
    $past(readout_on) |-> (ram_addr == $past(scan_pos)));

endmodule

bind charram_load_port charram_load_port_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/charram_load_port_tb_top.sv
module charram_load_port_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_valid;
  logic       wr_sel;
  logic [7:0] wr_byte;
  logic [9:0] scan_pos;
  logic       readout_on, addr_mode, maxspan_dot, lines16, chars40, spec_clip_en;
  logic [9:0] ram_addr;
  logic       ram_we;
  logic [7:0] ram_wdata, rd_data;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  logic [7:0] model   [1024];
  logic [9:0] loaded  [64];
  int         n_loaded = 0;

  always #4 clk = ~clk;  // 125 MHz

  charram_load_port dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .scan_pos(scan_pos), .readout_on(readout_on), .addr_mode(addr_mode),
    .maxspan_dot(maxspan_dot), .lines16(lines16), .chars40(chars40),
    .spec_clip_en(spec_clip_en), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .rd_data(rd_data)
  );

  function automatic logic [7:0] ctrl_byte(input logic rd, input logic sel,
                                          input logic [1:0] hi, input logic [3:0] modes);
    // bit0 readout, bit1 select, bit2 A9, bit3 maxspan, bit4 A8, bit5 16line, bit6 40char, bit7 clip
    return {modes[3], modes[2], modes[1], hi[0], modes[0], hi[1], sel, rd};
  endfunction

  function automatic logic [5:0] outs_of(input logic [7:0] c);
    return {c[7], c[6], c[5], c[3], c[1], c[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic sel, input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_byte = b;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; wr_byte = $urandom;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_char(input logic [9:0] a, input logic [7:0] d);
    host_wr(1'b0, ctrl_byte(1'b0, 1'b1, a[9:8], 4'h0));
    host_wr(1'b1, a[7:0]);
    check("R4 no write in address mode", ram_we, 1'b0);
    // R9: scramble the high bits while clearing select
    host_wr(1'b0, ctrl_byte(1'b0, 1'b0, ~a[9:8], 4'h0));
    check("R9 latched address held", ram_addr, a);
    host_wr(1'b1, d);
    check("R5 write strobe", ram_we, 1'b1);
    check("R5 write data", ram_wdata, d);
    wait_cyc(1);
    check("R5 write strobe one cycle", ram_we, 1'b0);
    model[a] = d;
  endtask

  task automatic read_back(input logic [9:0] a);
    host_wr(1'b0, ctrl_byte(1'b0, 1'b1, a[9:8], 4'h0));
    host_wr(1'b1, a[7:0]);
    wait_cyc(1);
    check("R3 latched address", ram_addr, a);
    wait_cyc(1);
    check("R8 read data", rd_data, model[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; wr_valid = 1'b0; wr_sel = 1'b0; wr_byte = '0; scan_pos = '0;
    wait_cyc(3);
    check("R1 ctrl outputs reset", {spec_clip_en, chars40, lines16, maxspan_dot, addr_mode, readout_on}, 6'h0);
    check("R1 ram_we reset", ram_we, 1'b0);
    check("R1 ram_addr reset", ram_addr, 10'h0);
    @(negedge clk); rst = 1'b0;
    wait_cyc(1);
    check("R1 after release", {readout_on, ram_we, ram_addr}, 12'h0);

    // R2: control fields, random mode patterns
    for (int i = 0; i < 8; i++) begin
      logic [7:0] c;
      c = $urandom;
      c[0] = 1'b0;
      host_wr(1'b0, c);
      check("R2 control fields", {spec_clip_en, chars40, lines16, maxspan_dot, addr_mode, readout_on}, outs_of(c));
    end
    host_wr(1'b0, 8'h00);

    // R7: strobe held, byte changes while high; last byte wins
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = 1'b0; wr_byte = 8'h68;
    wait_cyc(2);
    check("R7 no effect while strobe high", {lines16, chars40}, 2'b00);
    wr_byte = 8'hA8;
    @(negedge clk);
    wr_valid = 1'b0; wr_byte = 8'h00;
    @(negedge clk);
    check("R7 commit uses last byte", {spec_clip_en, chars40, lines16, maxspan_dot, addr_mode, readout_on}, outs_of(8'hA8));
    host_wr(1'b0, 8'h00);

    // Directed corners: extremes of the address space and flag bits
    load_char(10'h000, 8'h41);
    load_char(10'h3FF, 8'hC0);
    load_char(10'h200, 8'h7F);
    load_char(10'h100, 8'h80);
    n_loaded = 4;
    loaded[0] = 10'h000; loaded[1] = 10'h3FF; loaded[2] = 10'h200; loaded[3] = 10'h100;

    // Random loads
    for (int i = 0; i < 24; i++) begin
      logic [9:0] a;
      logic [7:0] d;
      a = $urandom; d = $urandom;
      load_char(a, d);
      loaded[n_loaded] = a;
      n_loaded++;
    end

    // R4 / R8: everything reads back; address-mode writes never disturbed memory
    for (int i = 0; i < n_loaded; i++) read_back(loaded[i]);

    // R6: readout on routes the scan counter
    host_wr(1'b0, ctrl_byte(1'b1, 1'b0, 2'b00, 4'h0));
    scan_pos = loaded[1];
    wait_cyc(1);
    check("R6 scan address", ram_addr, loaded[1]);
    wait_cyc(1);
    check("R8 read via scan", rd_data, model[loaded[1]]);
    for (int i = 0; i < 6; i++) begin
      logic [9:0] s;
      s = $urandom;
      scan_pos = s;
      wait_cyc(1);
      check("R6 scan follows one cycle", ram_addr, s);
    end
    host_wr(1'b0, ctrl_byte(1'b0, 1'b0, 2'b00, 4'h0));
    wait_cyc(1);
    check("R6 back to host latch", ram_addr, loaded[n_loaded-1]);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule